// File: doc/BRIEF.md
# Late-Write Synchronous Static Memory with Byte Lanes

This block is a single-clock synchronous static memory. Each word is 18 bits wide and split into two 9-bit byte lanes. Select, write enable, the two lane write selects and the address are captured on the rising clock edge. Read data is driven in the cycle after the read command. Write data follows its command by one cycle (late write). Each accepted write is parked in a one-entry pending buffer and is committed to the storage array when the next write's data arrives. Reads check the in-flight write and the pending entry first, lane by lane, so a read always sees the newest bytes.

The data bus is split into a capture input, a driven value and a drive enable, ready for a pad tristate. An active-low output enable and an active-high sleep input both gate the drive enable combinationally. Sleep also makes the block ignore any command sampled while it is high. A synchronous reset clears the read-valid, write-phase and pending flags. It does not touch the array contents. Depth is set by the address-width parameter.

Top module: `lw_sram`

## Requirements
- R1: A word is 18 bits: lane a is bits 8:0 and lane b is bits 17:9. `bw_n[0]` is the active-low write select of lane a and `bw_n[1]` that of lane b.
- R2: `cs_n`, `we_n`, `bw_n` and `addr` take effect only as sampled at a rising clock edge. Changing them between edges does not alter the operation already captured.
- R3: A cycle with `cs_n` high is a deselect: `dq_oe` is low throughout the following cycle.
- R4: A read (`cs_n` low, `we_n` high) drives the full addressed word on `dq_out` in the next cycle, with `dq_oe` high while `oe_n` is low and `sleep` is low.
- R5: While `sleep` is high, `dq_oe` is low at once, whatever the other inputs. Commands sampled while `sleep` is high are ignored.
- R6: `oe_n` high forces `dq_oe` low without a clock edge. A read issued with `oe_n` high still fetches its word, and lowering `oe_n` later in that data cycle exposes it.
- R7: For a write (`cs_n` low, `we_n` low) sampled at edge n, the data is taken from `dq_in` at edge n+1.
- R8: Only lanes whose write select is low are updated. A write with both selects high changes nothing.
- R9: A read returns the newest bytes of its address, merged lane by lane, from the write whose data is arriving at the same edge, then from the pending write, then from the array.
- R10: Reset clears the read-valid flag (the bus is undriven) and discards a pending write. Writes already committed to the array survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on rising edge |
| rst | input | 1 | Synchronous active-high reset of control flags |
| cs_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write enable |
| bw_n | input | 2 | Active-low lane write selects, bit 0 lane a, bit 1 lane b |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous sleep, forces bus undriven |
| dq_in | input | 18 | Write data, taken one cycle after its command |
| dq_out | output | 18 | Read data |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The hardest corner is a read that lands on the edge where a partial write's data arrives while an older write to the same address is being committed. A design with a wrong forwarding priority, or one that reads the array without bypass, returns stale lanes there. The bench also reads back right after a lane-only write. A design that ignores the lane selects, or swaps them, corrupts the untouched lane. Raising `oe_n` or `sleep` mid-cycle checks that gating is combinational and that a dummy read still fetches its word. Writes issued under sleep and a reset taken with a write still pending check that the first is dropped and that only the pending write is lost.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
endpackage

// File: rtl/lw_sram_lane_mem.sv
module lw_sram_lane_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first simple dual-port: infers block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_phase,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [WORD_W-1:0] din,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LANES-1:0]  commit_we,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [WORD_W-1:0] commit_data,
  output logic [LANES-1:0]  fwd_sel,
  output logic [WORD_W-1:0] fwd_data
);
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [WORD_W-1:0] pend_data;
  logic [LANES-1:0]  pend_mask;
  logic              hit_new, hit_old;
  logic [LANES-1:0]  sel_nxt;
  logic [WORD_W-1:0] data_nxt;

  assign hit_new     = wr_phase && (wr_addr == rd_addr);
  assign hit_old     = pend_v && (pend_addr == rd_addr);
  assign commit_addr = pend_addr;
  assign commit_data = pend_data;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign commit_we[i] = wr_phase && pend_v && pend_mask[i];
    always_comb begin
      if (hit_new && wr_mask[i]) begin
        sel_nxt[i] = 1'b1;
        data_nxt[i*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
      end else if (hit_old && pend_mask[i]) begin
        sel_nxt[i] = 1'b1;
        data_nxt[i*LANE_W +: LANE_W] = pend_data[i*LANE_W +: LANE_W];
      end else begin
        sel_nxt[i] = 1'b0;
        data_nxt[i*LANE_W +: LANE_W] = pend_data[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v  <= 1'b0;
      fwd_sel <= '0;
    end else begin
      if (wr_phase) pend_v <= 1'b1;
      fwd_sel <= sel_nxt;
    end
    if (wr_phase) begin
      pend_addr <= wr_addr;
      pend_data <= din;
      pend_mask <= wr_mask;
    end
    fwd_data <= data_nxt;
  end

  // R7: data taken in the write's data cycle lands in the pending entry
  a_r7_pend_loaded: assert property (@(posedge clk) disable iff (rst)
    wr_phase |=> pend_v && (pend_data == $past(din)));
  // R9: pending entry holds still between writes
  a_r9_pend_held: assert property (@(posedge clk) disable iff (rst)
    !wr_phase |=> $stable(pend_data) && $stable(pend_addr));
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe
);
  logic              rd_go, wr_go;
  logic              rd_v, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mask_q;
  logic [LANES-1:0]  commit_we, fwd_sel;
  logic [ADDR_W-1:0] commit_addr;
  logic [WORD_W-1:0] commit_data, fwd_data, ram_q;

  assign rd_go = !sleep && !cs_n && we_n;
  assign wr_go = !sleep && !cs_n && !we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_v <= rd_go;
      wr_q <= wr_go;
    end
    addr_q <= addr;
    mask_q <= ~bw_n;
  end

  lw_sram_wbuf #(.ADDR_W(ADDR_W)) u_wbuf (
    .clk(clk), .rst(rst), .wr_phase(wr_q), .wr_addr(addr_q), .wr_mask(mask_q),
    .din(dq_in), .rd_addr(addr), .commit_we(commit_we), .commit_addr(commit_addr),
    .commit_data(commit_data), .fwd_sel(fwd_sel), .fwd_data(fwd_data)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lw_sram_lane_mem #(.ADDR_W(ADDR_W), .DATA_W(LANE_W)) u_mem (
      .clk(clk), .we(commit_we[i]), .waddr(commit_addr),
      .wdata(commit_data[i*LANE_W +: LANE_W]), .raddr(addr),
      .rdata(ram_q[i*LANE_W +: LANE_W])
    );
    assign dq_out[i*LANE_W +: LANE_W] = fwd_sel[i] ? fwd_data[i*LANE_W +: LANE_W]
                                                   : ram_q[i*LANE_W +: LANE_W];
  end

  assign dq_oe = rd_v && !oe_n && !sleep;

  a_r3_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !dq_oe);
  a_r4_read_drives: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && we_n && !sleep) |=> (dq_oe || oe_n || sleep));
  a_r5_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dq_oe);
  a_r6_oe_quiet: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_oe);
endmodule

// File: tb/lw_sram_test.sv
module lw_sram_test;
  import lw_sram_pkg::*;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst, cs_n, we_n, oe_n, sleep;
  logic [LANES-1:0]  bw_n;
  logic [AW-1:0]     addr;
  logic [WORD_W-1:0] dq_in, dq_out;
  logic              dq_oe;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  localparam logic [17:0] D1 = 18'h2A5B3, D2 = 18'h1C0FE, D3 = 18'h12345;
  localparam logic [17:0] E1 = 18'h0ABCD, F1 = 18'h00F0F;

  always #4 clk = ~clk;

  lw_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .oe_n(oe_n), .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(string req, logic [17:0] act, logic [17:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, pass one rising edge, return at next negedge
  task automatic step(logic c, logic w, logic [1:0] b, logic [AW-1:0] a, logic [17:0] d);
    cs_n = c; we_n = w; bw_n = b; addr = a; dq_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_check(string req, logic [AW-1:0] a, logic [17:0] d, logic [17:0] exp);
    step(1'b0, 1'b1, 2'b11, a, d);
    check({req, " data"}, dq_out, exp);
    check({req, " drive"}, {17'd0, dq_oe}, 18'd1);
  endtask

  task automatic t_reset_state;
    check("R10 bus idle after reset", {17'd0, dq_oe}, 18'd0);
  endtask

  task automatic t_basic;
    step(1'b0, 1'b0, 2'b00, 6'd5, '0);
    step(1'b0, 1'b0, 2'b00, 6'd9, D1);
    step(1'b1, 1'b1, 2'b11, 6'd0, D2);
    rd_check("R7 R4 late write addr5", 6'd5, '0, D1);
    rd_check("R4 addr9", 6'd9, '0, D2);
    step(1'b1, 1'b1, 2'b11, 6'd5, '0);
    check("R3 deselect", {17'd0, dq_oe}, 18'd0);
  endtask

  task automatic t_lanes;
    step(1'b0, 1'b0, 2'b10, 6'd5, '0);      // lane a only
    rd_check("R8 R1 lane a only", 6'd5, 18'h3FFFF, {D1[17:9], 9'h1FF});
    step(1'b0, 1'b0, 2'b01, 6'd5, '0);      // lane b only
    rd_check("R8 R1 lane b only", 6'd5, 18'h00000, {9'h000, 9'h1FF});
    step(1'b0, 1'b0, 2'b11, 6'd5, '0);      // no lanes
    rd_check("R8 no lane selected", 6'd5, 18'h2AAAA, {9'h000, 9'h1FF});
  endtask

  task automatic t_merge;
    step(1'b0, 1'b0, 2'b00, 6'd12, '0);
    step(1'b0, 1'b0, 2'b10, 6'd12, D3);
    rd_check("R9 in-flight over pending", 6'd12, E1, {D3[17:9], E1[8:0]});
    rd_check("R9 pending over array", 6'd12, '0, {D3[17:9], E1[8:0]});
    step(1'b0, 1'b0, 2'b00, 6'd20, '0);
    rd_check("R9 read during commit", 6'd12, F1, {D3[17:9], E1[8:0]});
    rd_check("R9 from array", 6'd12, '0, {D3[17:9], E1[8:0]});
    rd_check("R9 newest write", 6'd20, '0, F1);
  endtask

  task automatic t_oe;
    oe_n = 1'b1;
    step(1'b0, 1'b1, 2'b11, 6'd9, '0);
    check("R6 dummy read undriven", {17'd0, dq_oe}, 18'd0);
    oe_n = 1'b0;
    #1;
    check("R6 late enable drives", {17'd0, dq_oe}, 18'd1);
    check("R6 late enable data", dq_out, D2);
    oe_n = 1'b1;
    #1;
    check("R6 disable mid-cycle", {17'd0, dq_oe}, 18'd0);
    oe_n = 1'b0;
  endtask

  task automatic t_sleep;
    step(1'b0, 1'b1, 2'b11, 6'd9, '0);
    sleep = 1'b1;
    #1;
    check("R5 sleep forces undriven", {17'd0, dq_oe}, 18'd0);
    step(1'b0, 1'b0, 2'b00, 6'd9, '0);
    step(1'b1, 1'b1, 2'b11, 6'd0, 18'h3FFFF);
    sleep = 1'b0;
    rd_check("R5 write under sleep ignored", 6'd9, '0, D2);
  endtask

  task automatic t_edge;
    cs_n = 1'b0; we_n = 1'b1; bw_n = 2'b11; addr = 6'd5;
    @(posedge clk);
    #1;
    addr = 6'd9; cs_n = 1'b1; we_n = 1'b0; bw_n = 2'b00;
    @(negedge clk);
    check("R2 sampled address kept", dq_out, {9'h000, 9'h1FF});
    check("R2 sampled read kept", {17'd0, dq_oe}, 18'd1);
    step(1'b1, 1'b1, 2'b11, 6'd0, '0);
  endtask

  task automatic t_reset_pend;
    step(1'b0, 1'b0, 2'b00, 6'd30, '0);
    step(1'b0, 1'b0, 2'b00, 6'd31, 18'h11111);
    step(1'b0, 1'b0, 2'b00, 6'd30, 18'h22222);
    step(1'b1, 1'b1, 2'b11, 6'd0, 18'h33333);
    rd_check("R9 pending visible before reset", 6'd30, '0, 18'h33333);
    rst = 1'b1;
    step(1'b1, 1'b1, 2'b11, 6'd0, '0);
    rst = 1'b0;
    check("R10 reset drops drive", {17'd0, dq_oe}, 18'd0);
    rd_check("R10 pending write lost", 6'd30, '0, 18'h11111);
    rd_check("R10 committed write kept", 6'd31, '0, 18'h22222);
  endtask

  initial begin
    rst = 1'b1; cs_n = 1'b1; we_n = 1'b1; bw_n = 2'b11; addr = '0;
    oe_n = 1'b0; sleep = 1'b0; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_basic();
    t_lanes();
    t_merge();
    t_oe();
    t_sleep();
    t_edge();
    t_reset_pend();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule